// File: doc/BRIEF.md
# Floating-Point and Trace Access Control Register

This block holds one 32-bit control word that a processor core writes and reads over a simple system-register port. The word carries the enables that other logic uses to decide whether floating-point/SIMD instructions may run, whether SIMD-only instructions are blocked, and whether trace system registers may be touched. The block only stores the word, resets it, masks writes and shapes what a read returns. The permission decode that consumes the bits and the trap decision for the access itself belong to other blocks.

Three override inputs come from a control register that only secure software can program. While the core runs in non-secure state, these overrides can force a field to read as one, force it to read as zero, or turn writes to it into no-ops. The stored bits stay as they are, so a field's earlier value shows up again once its override is lifted. Two parameters state whether the floating-point/SIMD unit and the trace register interface exist. When a unit is absent, its fields read as zero.

Reads are registered: the value is captured on the edge that samples the read strobe and is shown for one cycle with a valid flag. A small two-state read controller runs this. `RDP_IDLE` moves to `RDP_RESP` when the read strobe is sampled. `RDP_RESP` stays in `RDP_RESP` on a back-to-back strobe and returns to `RDP_IDLE` otherwise.

Top module: `coproc_access_ctl`

## Requirements
- R1: After reset, a read returns 0x00000000 and `rd_valid` is low until the first read.
- R2: Bits 30:29, 27:24 and 19:0 always read as zero, even after writing all ones.
- R3: In secure state, a write stores bit 31 (SIMD-only disable), bit 28 (trace register disable) and bits 21:20 (access field, 00 none, 01 privileged only, 11 full), and a later read returns them.
- R4: Bits 23:22 read as a copy of what bits 21:20 read; a value written to 23:22 is discarded.
- R5: In non-secure state with `sec_cp_allow` = 0, bits 23:20 read as zero and writes to bits 21:20 do not change the stored value.
- R6: In non-secure state with `sec_simd_off` = 1, bit 31 reads as one and writes to bit 31 do not change the stored value.
- R7: In non-secure state with `sec_trace_off` = 1, bit 28 reads as one and writes to bit 28 do not change the stored value.
- R8: In secure state (`nonsec` = 0), all three override inputs have no effect on reads or writes.
- R9: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high. `rd_data` changes only after such a cycle and otherwise holds its value.
- R10: A read and a write in the same cycle return the value held before the write; the write is visible to the next read.
- R11: Lifting an override exposes the previously stored field value unchanged.
- R12: With `HAS_FPU` = 0, bits 31 and 23:20 read as zero. With `HAS_TRACE` = 0, bit 28 reads as zero. This holds whatever the writes and overrides are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low warm reset, synchronous |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read value |
| rd_valid | output | 1 | High in the cycle `rd_data` holds a fresh read |
| nonsec | input | 1 | 1 = core is in non-secure state |
| sec_cp_allow | input | 1 | Secure override: 0 blocks non-secure use of the access fields |
| sec_simd_off | input | 1 | Secure override: 1 forces SIMD-only disable in non-secure state |
| sec_trace_off | input | 1 | Secure override: 1 forces trace disable in non-secure state |

## Verification
The two functions that can coincide are the write path and the read capture. Both sample at the same clock edge, and a read must not observe the write it shares a cycle with. The bench provokes this by raising `wr_en` and `rd_en` together with new data. It expects the captured word to equal the earlier stored value, and a following read to show the new value. The override paths are judged in a similar way: the bench writes under an override, lifts the override, and then checks that the stored bit came through untouched.

// File: rtl/cpac_pkg.sv
package cpac_pkg;

    localparam int REG_W    = 32;
    localparam int FLD_W    = 2;
    localparam int SIMD_BIT = 31;
    localparam int TRC_BIT  = 28;
    localparam int CPA_LO   = 20;
    localparam int CPB_LO   = 22;
    localparam int CPA_HI   = CPA_LO + FLD_W - 1;
    localparam int CPB_HI   = CPB_LO + FLD_W - 1;

    localparam logic [REG_W-1:0] LIVE_MASK =
        (REG_W'(1) << SIMD_BIT) | (REG_W'(1) << TRC_BIT) |
        (REG_W'(3) << CPA_LO)   | (REG_W'(3) << CPB_LO);

    typedef struct packed {
        logic             simd_off;
        logic             trc_off;
        logic [FLD_W-1:0] cp_acc;
    } cpac_store_t;

    typedef enum logic {
        RDP_IDLE = 1'b0,
        RDP_RESP = 1'b1
    } rdp_state_t;

endpackage

// File: rtl/cpac_store.sv
module cpac_store
    import cpac_pkg::*;
#(
    parameter bit HAS_FPU   = 1'b1,
    parameter bit HAS_TRACE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wd_simd,
    input  logic             wd_trc,
    input  logic [FLD_W-1:0] wd_cp,
    input  logic             nonsec,
    input  logic             sec_cp_allow,
    input  logic             sec_simd_off,
    input  logic             sec_trace_off,
    output cpac_store_t      st
);

    generate
        if (HAS_FPU) begin : g_fpu
            logic             simd_q;
            logic [FLD_W-1:0] cp_q;
            logic             simd_we;
            logic             cp_we;

            always_comb begin
                simd_we = wr_en && !(nonsec && sec_simd_off);
                cp_we   = wr_en && !(nonsec && !sec_cp_allow);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    simd_q <= 1'b0;
                    cp_q   <= '0;
                end else begin
                    if (simd_we) simd_q <= wd_simd;
                    if (cp_we)   cp_q   <= wd_cp;
                end
            end

            assign st.simd_off = simd_q;
            assign st.cp_acc   = cp_q;
        end else begin : g_no_fpu
            wire unused_fpu_in = ^{wd_simd, wd_cp, sec_cp_allow, sec_simd_off};
            assign st.simd_off = 1'b0;
            assign st.cp_acc   = '0;
        end

        if (HAS_TRACE) begin : g_trc
            logic trc_q;
            logic trc_we;

            always_comb trc_we = wr_en && !(nonsec && sec_trace_off);

            always_ff @(posedge clk) begin
                if (!rst_n)      trc_q <= 1'b0;
                else if (trc_we) trc_q <= wd_trc;
            end

            assign st.trc_off = trc_q;
        end else begin : g_no_trc
            wire unused_trc_in = ^{wd_trc, sec_trace_off};
            assign st.trc_off = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/cpac_view.sv
module cpac_view
    import cpac_pkg::*;
#(
    parameter bit HAS_FPU   = 1'b1,
    parameter bit HAS_TRACE = 1'b1
) (
    input  cpac_store_t      st,
    input  logic             nonsec,
    input  logic             sec_cp_allow,
    input  logic             sec_simd_off,
    input  logic             sec_trace_off,
    output logic [REG_W-1:0] word
);

    logic [FLD_W-1:0] cp_seen;

    always_comb begin
        word    = '0;
        cp_seen = (nonsec && !sec_cp_allow) ? '0 : st.cp_acc;
        if (HAS_FPU) begin
            word[SIMD_BIT]      = st.simd_off | (nonsec & sec_simd_off);
            word[CPA_HI:CPA_LO] = cp_seen;
            word[CPB_HI:CPB_LO] = cp_seen;
        end
        if (HAS_TRACE) begin
            word[TRC_BIT] = st.trc_off | (nonsec & sec_trace_off);
        end
    end

endmodule

// File: rtl/cpac_rdport.sv
module cpac_rdport
    import cpac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [REG_W-1:0] word,
    output logic [REG_W-1:0] rd_data,
    output logic             rd_valid
);

    rdp_state_t state_q;
    rdp_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RDP_IDLE: state_d = rd_en ? RDP_RESP : RDP_IDLE;
            RDP_RESP: state_d = rd_en ? RDP_RESP : RDP_IDLE;
            default:  state_d = RDP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RDP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= word;
    end

    assign rd_valid = (state_q == RDP_RESP);

endmodule

// File: rtl/coproc_access_ctl.sv
module coproc_access_ctl
    import cpac_pkg::*;
#(
    parameter bit HAS_FPU   = 1'b1,
    parameter bit HAS_TRACE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    output logic             rd_valid,
    input  logic             nonsec,
    input  logic             sec_cp_allow,
    input  logic             sec_simd_off,
    input  logic             sec_trace_off
);

    cpac_store_t      st;
    logic [REG_W-1:0] view_word;

    wire unused_wr_bits = ^(wr_data & ~(REG_W'(1) << SIMD_BIT) &
                            ~(REG_W'(1) << TRC_BIT) & ~(REG_W'(3) << CPA_LO));

    cpac_store #(.HAS_FPU(HAS_FPU), .HAS_TRACE(HAS_TRACE)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wd_simd       (wr_data[SIMD_BIT]),
        .wd_trc        (wr_data[TRC_BIT]),
        .wd_cp         (wr_data[CPA_HI:CPA_LO]),
        .nonsec        (nonsec),
        .sec_cp_allow  (sec_cp_allow),
        .sec_simd_off  (sec_simd_off),
        .sec_trace_off (sec_trace_off),
        .st            (st)
    );

    cpac_view #(.HAS_FPU(HAS_FPU), .HAS_TRACE(HAS_TRACE)) u_view (
        .st            (st),
        .nonsec        (nonsec),
        .sec_cp_allow  (sec_cp_allow),
        .sec_simd_off  (sec_simd_off),
        .sec_trace_off (sec_trace_off),
        .word          (view_word)
    );

    cpac_rdport u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .word     (view_word),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/cpac_checker.sv
module cpac_checker
    import cpac_pkg::*;
#(
    parameter bit HAS_FPU   = 1'b1,
    parameter bit HAS_TRACE = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [REG_W-1:0] rd_data,
    input logic             rd_valid,
    input logic             nonsec,
    input logic             sec_cp_allow,
    input logic             sec_simd_off,
    input logic             sec_trace_off
);

    // R9: valid follows the strobe by one cycle
    a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R2: reserved bits never read as one
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & ~LIVE_MASK) == '0));

    // R4: upper access field mirrors lower
    a_r4_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[CPB_HI:CPB_LO] == rd_data[CPA_HI:CPA_LO]));

    // R5: blocked access fields read zero
    a_r5_cp_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && nonsec && !sec_cp_allow) |=> (rd_data[CPB_HI:CPA_LO] == '0));

    // R6: SIMD disable forced on
    a_r6_simd_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_FPU && rd_en && nonsec && sec_simd_off) |=> rd_data[SIMD_BIT]);

    // R7: trace disable forced on
    a_r7_trace_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_TRACE && rd_en && nonsec && sec_trace_off) |=> rd_data[TRC_BIT]);

    // R12: absent units read zero
    a_r12_absent_fpu: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_FPU && rd_valid) |-> (rd_data[SIMD_BIT] == 1'b0 && rd_data[CPB_HI:CPA_LO] == '0));
    a_r12_absent_trace: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_TRACE && rd_valid) |-> (rd_data[TRC_BIT] == 1'b0));

endmodule

bind coproc_access_ctl cpac_checker #(.HAS_FPU(HAS_FPU), .HAS_TRACE(HAS_TRACE)) u_cpac_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (rd_en),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .nonsec        (nonsec),
    .sec_cp_allow  (sec_cp_allow),
    .sec_simd_off  (sec_simd_off),
    .sec_trace_off (sec_trace_off)
);

// File: tb/test_coproc_access_ctl.sv
module test_coproc_access_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        nonsec = 1'b0;
    logic        sec_cp_allow = 1'b1;
    logic        sec_simd_off = 1'b0;
    logic        sec_trace_off = 1'b0;
    logic [31:0] rd_data, rd_data_b;
    logic        rd_valid, rd_valid_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    coproc_access_ctl i_coproc_access_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .nonsec(nonsec), .sec_cp_allow(sec_cp_allow),
        .sec_simd_off(sec_simd_off), .sec_trace_off(sec_trace_off));

    coproc_access_ctl #(.HAS_FPU(1'b0), .HAS_TRACE(1'b0)) i_coproc_access_ctl_bare (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data_b), .rd_valid(rd_valid_b),
        .nonsec(nonsec), .sec_cp_allow(sec_cp_allow),
        .sec_simd_off(sec_simd_off), .sec_trace_off(sec_trace_off));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk({req, " valid"}, {31'd0, rd_valid}, 32'd1);
        chk(req, rd_data, exp);
        chk("R12 bare", rd_data_b, 32'h0);
    endtask

    task automatic set_ctx(input logic ns, input logic cpa, input logic so, input logic to);
        @(negedge clk);
        nonsec = ns; sec_cp_allow = cpa; sec_simd_off = so; sec_trace_off = to;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid low", {31'd0, rd_valid}, 32'd0);
        rd("R1 reset value", 32'h0000_0000);
    endtask

    task automatic t_secure_rw();
        set_ctx(0, 1, 0, 0);
        wr(32'hFFFF_FFFF);
        rd("R2 R3 all ones", 32'h90F0_0000);
        wr(32'h0010_0000);
        rd("R3 priv only", 32'h0050_0000);
        wr(32'h00C0_0000);
        rd("R4 upper discarded", 32'h0000_0000);
    endtask

    task automatic t_ns_cp();
        set_ctx(0, 1, 0, 0);
        wr(32'h0030_0000);
        set_ctx(1, 0, 0, 0);
        rd("R5 fields zero", 32'h0000_0000);
        wr(32'h0010_0000);
        rd("R5 still zero", 32'h0000_0000);
        set_ctx(1, 1, 0, 0);
        rd("R11 R5 stored kept", 32'h00F0_0000);
    endtask

    task automatic t_ns_simd();
        set_ctx(0, 1, 0, 0);
        wr(32'h8000_0000);
        set_ctx(1, 1, 1, 0);
        wr(32'h0000_0000);
        rd("R6 forced one", 32'h8000_0000);
        set_ctx(1, 1, 0, 0);
        rd("R6 R11 write ignored", 32'h8000_0000);
        set_ctx(0, 1, 0, 0);
        wr(32'h0000_0000);
        set_ctx(1, 1, 1, 0);
        rd("R6 forced over zero", 32'h8000_0000);
        set_ctx(1, 1, 0, 0);
        rd("R11 simd exposed", 32'h0000_0000);
    endtask

    task automatic t_ns_trace();
        set_ctx(0, 1, 0, 0);
        wr(32'h1000_0000);
        set_ctx(1, 1, 0, 1);
        wr(32'h0000_0000);
        rd("R7 forced one", 32'h1000_0000);
        set_ctx(1, 1, 0, 0);
        rd("R7 R11 write ignored", 32'h1000_0000);
        set_ctx(0, 1, 0, 0);
        wr(32'h0000_0000);
        set_ctx(1, 1, 0, 1);
        rd("R7 forced over zero", 32'h1000_0000);
        set_ctx(1, 1, 0, 0);
        rd("R11 trace exposed", 32'h0000_0000);
    endtask

    task automatic t_secure_ignores();
        set_ctx(0, 0, 1, 1);
        wr(32'h0030_0000);
        rd("R8 overrides ignored", 32'h00F0_0000);
        wr(32'h0000_0000);
        rd("R8 write zero", 32'h0000_0000);
    endtask

    task automatic t_same_cycle();
        set_ctx(0, 1, 0, 0);
        wr(32'h0000_0000);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h8030_0000; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 old value", rd_data, 32'h0000_0000);
        rd("R10 new value", 32'h80F0_0000);
    endtask

    task automatic t_hold();
        logic [31:0] snap;
        rd("R9 fresh", 32'h80F0_0000);
        snap = rd_data;
        wr(32'h0000_0000);
        @(negedge clk);
        chk("R9 valid dropped", {31'd0, rd_valid}, 32'd0);
        chk("R9 data held", rd_data, snap);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_secure_rw();
        t_ns_cp();
        t_ns_simd();
        t_ns_trace();
        t_secure_ignores();
        t_same_cycle();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule